// File: doc/BRIEF.md
# Partitioned Graph Scatter/Gather Engine

This block runs both phases of one edge-centric graph iteration for a single partition. It keeps that partition's vertex labels, with one active flag per vertex, in a small on-chip table. The engine is used once per partition and per phase. All partitions cover the same power-of-two number of contiguous vertex indices. The partition number is an input. The vertex identifier is the partition number in its upper bits, followed by the local offset in its lower bits.

In scatter mode the engine takes a stream of edges (source, destination). For each edge it reads the source's label and flag and sends out one update. The update carries the destination, the label, the flag, and the index of the destination's partition, called its bin. The shard is sorted by destination, so updates leave grouped by bin. A strobe marks the first update of each new bin. In gather mode the engine takes a stream of updates and folds each one into its interval with a minimum. A vertex whose label drops is marked active.

A start pulse opens a pass. A done pulse follows the element carrying the last flag. Both streams use valid/ready handshakes.

Top module: `sg_engine`

## Requirements
- R1: After reset every label is all ones and every active flag is clear. `upd_out_valid`, `pass_done` and `pass_count` are zero.
- R2: In scatter mode, an edge accepted at a clock edge gives one update valid right after that edge. The update carries the edge's destination, plus the label and active flag of the local vertex addressed by the source's low `IVL_LOG2` bits.
- R3: An emitted update's bin equals its destination shifted right by `IVL_LOG2`.
- R4: `upd_out_bin_chg` is 1 on the first update after a start pulse. It is also 1 on any update whose bin differs from the previously emitted update's bin, and 0 otherwise.
- R5: In scatter mode `edge_ready` = !`upd_out_valid` || `upd_out_ready`, so one edge per clock passes when not back-pressured. While a valid update waits with `upd_out_ready` low, all update outputs hold steady.
- R6: In gather mode an update whose destination's upper `PART_W` bits equal `part_idx`, and whose value is strictly below the stored label, replaces that label and sets the vertex's active flag. A value equal to or above the stored label changes nothing.
- R7: In gather mode an update whose destination lies outside the partition changes no label and no flag.
- R8: `mode` = 0 selects scatter and `mode` = 1 selects gather. `edge_ready` is 0 in gather mode. `upd_in_ready` is 1 in gather mode and 0 in scatter mode.
- R9: A start pulse sets `pass_count` to zero and restarts the bin history. A start pulse with `mode` = 1 clears every active flag.
- R10: `pass_count` counts the input elements accepted since the last start. `pass_done` is high for the one cycle after an element with its last flag is accepted. An emitted update's `upd_out_last` copies the flag of its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 1 | 0 scatter, 1 gather |
| start | input | 1 | Opens a pass |
| part_idx | input | PART_W | Partition served by the engine |
| edge_valid | input | 1 | Edge present |
| edge_ready | output | 1 | Edge accepted |
| edge_src | input | PART_W+IVL_LOG2 | Edge source vertex |
| edge_dst | input | PART_W+IVL_LOG2 | Edge destination vertex |
| edge_last | input | 1 | Final edge of the shard |
| upd_in_valid | input | 1 | Incoming update present |
| upd_in_ready | output | 1 | Incoming update accepted |
| upd_in_dst | input | PART_W+IVL_LOG2 | Incoming update target vertex |
| upd_in_val | input | LBL_W | Incoming update value |
| upd_in_last | input | 1 | Final incoming update |
| upd_out_valid | output | 1 | Emitted update present |
| upd_out_ready | input | 1 | Downstream takes the update |
| upd_out_dst | output | PART_W+IVL_LOG2 | Emitted update target |
| upd_out_val | output | LBL_W | Source label |
| upd_out_bin | output | PART_W | Target bin |
| upd_out_src_act | output | 1 | Source active flag |
| upd_out_bin_chg | output | 1 | First update of a new bin |
| upd_out_last | output | 1 | Update came from the final edge |
| pass_count | output | CNT_W | Elements accepted this pass |
| pass_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Properties check on every cycle that:
- the ready outputs follow the mode;
- a stalled update holds steady;
- a gather write leaves the written label and its flag set;
- a start zeroes the count.

The bench scenarios are needed for the rest:
- the value semantics of the minimum, including the ignored out-of-partition and non-improving updates;
- the grouping strobe across a destination-sorted stream;
- the link between a gather pass and the labels a later scatter pass reads back;
- the clearing of active flags by a gather start.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic {
        SG_SCATTER = 1'b0,
        SG_GATHER  = 1'b1
    } sg_mode_e;
endpackage

// File: rtl/sg_interval_mem.sv
module sg_interval_mem #(
    parameter int IDX_W = 4,
    parameter int LBL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LBL_W-1:0] rd_lbl,
    output logic             rd_act,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LBL_W-1:0] wr_lbl,
    input  logic             clr_act
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][LBL_W-1:0] lbl;
        logic [DEPTH-1:0]            act;
    } mem_t;

    mem_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_act) st_d.act = '0;
        if (wr_en) begin
            st_d.lbl[wr_idx] = wr_lbl;
            st_d.act[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lbl <= '1;
            st_q.act <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_lbl = st_q.lbl[rd_idx];
    assign rd_act = st_q.act[rd_idx];

    // R6: a lowered label is stored and its vertex marked active
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.act[$past(wr_idx)] && st_q.lbl[$past(wr_idx)] == $past(wr_lbl)));
endmodule

// File: rtl/sg_gather_min.sv
module sg_gather_min #(
    parameter int PART_W   = 4,
    parameter int IVL_LOG2 = 4,
    parameter int LBL_W    = 8
) (
    input  logic                       fire,
    input  logic [PART_W-1:0]          part_idx,
    input  logic [PART_W+IVL_LOG2-1:0] upd_dst,
    input  logic [LBL_W-1:0]           upd_val,
    input  logic [LBL_W-1:0]           cur_lbl,
    output logic                       wr_en,
    output logic [IVL_LOG2-1:0]        wr_idx,
    output logic [LBL_W-1:0]           wr_lbl
);
    localparam int VTX_W = PART_W + IVL_LOG2;

    logic in_part;
    logic lower;

    always_comb begin
        in_part = (upd_dst[VTX_W-1 -: PART_W] == part_idx);
        lower   = (upd_val < cur_lbl);
        wr_en   = fire && in_part && lower;
        wr_idx  = upd_dst[IVL_LOG2-1:0];
        wr_lbl  = upd_val;
    end
endmodule

// File: rtl/sg_scatter_stage.sv
module sg_scatter_stage #(
    parameter int PART_W   = 4,
    parameter int IVL_LOG2 = 4,
    parameter int LBL_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       clr_hist,
    input  logic [PART_W+IVL_LOG2-1:0] in_dst,
    input  logic [LBL_W-1:0]           in_val,
    input  logic                       in_act,
    input  logic                       in_last,
    output logic                       can_take,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [PART_W+IVL_LOG2-1:0] out_dst,
    output logic [LBL_W-1:0]           out_val,
    output logic [PART_W-1:0]          out_bin,
    output logic                       out_act,
    output logic                       out_chg,
    output logic                       out_last
);
    localparam int VTX_W = PART_W + IVL_LOG2;

    typedef struct packed {
        logic              valid;
        logic [VTX_W-1:0]  dst;
        logic [LBL_W-1:0]  val;
        logic [PART_W-1:0] bin;
        logic              act;
        logic              chg;
        logic              last;
        logic [PART_W-1:0] prev_bin;
        logic              first;
    } stg_t;

    stg_t st_d, st_q;
    logic [PART_W-1:0] new_bin;

    always_comb begin
        st_d    = st_q;
        new_bin = in_dst[VTX_W-1 -: PART_W];
        if (out_ready) st_d.valid = 1'b0;
        if (load) begin
            st_d.valid    = 1'b1;
            st_d.dst      = in_dst;
            st_d.val      = in_val;
            st_d.bin      = new_bin;
            st_d.act      = in_act;
            st_d.last     = in_last;
            st_d.chg      = st_q.first || (new_bin != st_q.prev_bin);
            st_d.prev_bin = new_bin;
            st_d.first    = 1'b0;
        end
        if (clr_hist) st_d.first = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign can_take  = !st_q.valid || out_ready;
    assign out_valid = st_q.valid;
    assign out_dst   = st_q.dst;
    assign out_val   = st_q.val;
    assign out_bin   = st_q.bin;
    assign out_act   = st_q.act;
    assign out_chg   = st_q.chg;
    assign out_last  = st_q.last;

    // R5: a waiting update keeps its contents
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dst) && $stable(out_val)
                                       && $stable(out_bin) && $stable(out_chg)));
endmodule

// File: rtl/sg_engine.sv
module sg_engine #(
    parameter int PART_W   = 4,
    parameter int IVL_LOG2 = 4,
    parameter int LBL_W    = 8,
    parameter int CNT_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode,
    input  logic                       start,
    input  logic [PART_W-1:0]          part_idx,
    input  logic                       edge_valid,
    output logic                       edge_ready,
    input  logic [PART_W+IVL_LOG2-1:0] edge_src,
    input  logic [PART_W+IVL_LOG2-1:0] edge_dst,
    input  logic                       edge_last,
    input  logic                       upd_in_valid,
    output logic                       upd_in_ready,
    input  logic [PART_W+IVL_LOG2-1:0] upd_in_dst,
    input  logic [LBL_W-1:0]           upd_in_val,
    input  logic                       upd_in_last,
    output logic                       upd_out_valid,
    input  logic                       upd_out_ready,
    output logic [PART_W+IVL_LOG2-1:0] upd_out_dst,
    output logic [LBL_W-1:0]           upd_out_val,
    output logic [PART_W-1:0]          upd_out_bin,
    output logic                       upd_out_src_act,
    output logic                       upd_out_bin_chg,
    output logic                       upd_out_last,
    output logic [CNT_W-1:0]           pass_count,
    output logic                       pass_done
);
    import sg_pkg::*;

    sg_mode_e cur_mode;
    logic     stage_take;
    logic     edge_fire, upd_fire, any_fire, any_last;

    logic [IVL_LOG2-1:0] rd_idx;
    logic [LBL_W-1:0]    rd_lbl;
    logic                rd_act;
    logic                wr_en;
    logic [IVL_LOG2-1:0] wr_idx;
    logic [LBL_W-1:0]    wr_lbl;
    logic                clr_act;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        cur_mode     = sg_mode_e'(mode);
        edge_ready   = (cur_mode == SG_SCATTER) && stage_take;
        upd_in_ready = (cur_mode == SG_GATHER);
        edge_fire    = edge_valid && edge_ready;
        upd_fire     = upd_in_valid && upd_in_ready;
        any_fire     = edge_fire || upd_fire;
        any_last     = (edge_fire && edge_last) || (upd_fire && upd_in_last);
        rd_idx       = (cur_mode == SG_GATHER) ? upd_in_dst[IVL_LOG2-1:0]
                                               : edge_src[IVL_LOG2-1:0];
        clr_act      = start && (cur_mode == SG_GATHER);
    end

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.cnt  = '0;
            ctl_d.done = 1'b0;
        end else begin
            ctl_d.cnt  = ctl_q.cnt + CNT_W'(any_fire);
            ctl_d.done = any_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pass_count = ctl_q.cnt;
    assign pass_done  = ctl_q.done;

    sg_interval_mem #(.IDX_W(IVL_LOG2), .LBL_W(LBL_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_lbl  (rd_lbl),
        .rd_act  (rd_act),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_lbl  (wr_lbl),
        .clr_act (clr_act)
    );

    sg_gather_min #(.PART_W(PART_W), .IVL_LOG2(IVL_LOG2), .LBL_W(LBL_W)) i_gather (
        .fire     (upd_fire),
        .part_idx (part_idx),
        .upd_dst  (upd_in_dst),
        .upd_val  (upd_in_val),
        .cur_lbl  (rd_lbl),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_lbl   (wr_lbl)
    );

    sg_scatter_stage #(.PART_W(PART_W), .IVL_LOG2(IVL_LOG2), .LBL_W(LBL_W)) i_scatter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (edge_fire),
        .clr_hist  (start),
        .in_dst    (edge_dst),
        .in_val    (rd_lbl),
        .in_act    (rd_act),
        .in_last   (edge_last),
        .can_take  (stage_take),
        .out_ready (upd_out_ready),
        .out_valid (upd_out_valid),
        .out_dst   (upd_out_dst),
        .out_val   (upd_out_val),
        .out_bin   (upd_out_bin),
        .out_act   (upd_out_src_act),
        .out_chg   (upd_out_bin_chg),
        .out_last  (upd_out_last)
    );

    // R8: gather mode refuses edges
    assert_no_edges_in_gather_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> !edge_ready);
    // R8: scatter mode refuses incoming updates
    assert_no_updates_in_scatter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> !upd_in_ready);
    // R9: a start leaves the counter at zero
    assert_start_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pass_count == '0));
endmodule

// File: tb/test_sg_engine.sv
module test_sg_engine;
    localparam int PART_W   = 4;
    localparam int IVL_LOG2 = 4;
    localparam int LBL_W    = 8;
    localparam int CNT_W    = 16;
    localparam int VTX_W    = PART_W + IVL_LOG2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, start = 1'b0;
    logic [PART_W-1:0] part_idx = 4'd2;
    logic edge_valid = 1'b0, edge_last = 1'b0;
    logic [VTX_W-1:0] edge_src = '0, edge_dst = '0;
    logic edge_ready;
    logic upd_in_valid = 1'b0, upd_in_last = 1'b0;
    logic [VTX_W-1:0] upd_in_dst = '0;
    logic [LBL_W-1:0] upd_in_val = '0;
    logic upd_in_ready;
    logic upd_out_ready = 1'b1;
    logic upd_out_valid, upd_out_src_act, upd_out_bin_chg, upd_out_last;
    logic [VTX_W-1:0] upd_out_dst;
    logic [LBL_W-1:0] upd_out_val;
    logic [PART_W-1:0] upd_out_bin;
    logic [CNT_W-1:0] pass_count;
    logic pass_done;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sg_engine #(.PART_W(PART_W), .IVL_LOG2(IVL_LOG2), .LBL_W(LBL_W), .CNT_W(CNT_W)) i_sg_engine (
        .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .part_idx(part_idx),
        .edge_valid(edge_valid), .edge_ready(edge_ready), .edge_src(edge_src),
        .edge_dst(edge_dst), .edge_last(edge_last),
        .upd_in_valid(upd_in_valid), .upd_in_ready(upd_in_ready), .upd_in_dst(upd_in_dst),
        .upd_in_val(upd_in_val), .upd_in_last(upd_in_last),
        .upd_out_valid(upd_out_valid), .upd_out_ready(upd_out_ready),
        .upd_out_dst(upd_out_dst), .upd_out_val(upd_out_val), .upd_out_bin(upd_out_bin),
        .upd_out_src_act(upd_out_src_act), .upd_out_bin_chg(upd_out_bin_chg),
        .upd_out_last(upd_out_last), .pass_count(pass_count), .pass_done(pass_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic m);
        mode  = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 count zero after start", 32'(pass_count), 0);
    endtask

    // drives one edge at a falling edge, checks its update one cycle later
    task automatic send_edge(input logic [VTX_W-1:0] s, input logic [VTX_W-1:0] d,
                             input logic lst, input logic [LBL_W-1:0] ev,
                             input logic ea, input logic ec);
        edge_valid = 1'b1;
        edge_src   = s;
        edge_dst   = d;
        edge_last  = lst;
        @(negedge clk);
        chk("R2 out valid", 32'(upd_out_valid), 1);
        chk("R2 out dst", 32'(upd_out_dst), 32'(d));
        chk("R2 out val", 32'(upd_out_val), 32'(ev));
        chk("R2 out act", 32'(upd_out_src_act), 32'(ea));
        chk("R3 out bin", 32'(upd_out_bin), 32'(d >> IVL_LOG2));
        chk("R4 bin change", 32'(upd_out_bin_chg), 32'(ec));
        chk("R10 out last", 32'(upd_out_last), 32'(lst));
    endtask

    task automatic send_upd(input logic [VTX_W-1:0] d, input logic [LBL_W-1:0] v,
                            input logic lst);
        upd_in_valid = 1'b1;
        upd_in_dst   = d;
        upd_in_val   = v;
        upd_in_last  = lst;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 out valid", 32'(upd_out_valid), 0);
        chk("R1 count", 32'(pass_count), 0);
        chk("R1 done", 32'(pass_done), 0);
        chk("R5 ready idle", 32'(edge_ready), 1);
    endtask

    task automatic t_gather;
        pulse_start(1'b1);
        chk("R8 edge_ready gather", 32'(edge_ready), 0);
        chk("R8 upd_in_ready gather", 32'(upd_in_ready), 1);
        send_upd(8'h23, 8'd10, 1'b0);   // R6 lowers label
        send_upd(8'h23, 8'd20, 1'b0);   // R6 larger value ignored
        send_upd(8'h45, 8'd1,  1'b0);   // R7 other partition
        send_upd(8'h2F, 8'd3,  1'b1);
        upd_in_valid = 1'b0;
        upd_in_last  = 1'b0;
        chk("R10 done after last", 32'(pass_done), 1);
        chk("R10 gather count", 32'(pass_count), 4);
        @(negedge clk);
        chk("R10 done one cycle", 32'(pass_done), 0);
    endtask

    task automatic t_scatter;
        pulse_start(1'b0);
        chk("R8 edge_ready scatter", 32'(edge_ready), 1);
        chk("R8 upd_in_ready scatter", 32'(upd_in_ready), 0);
        send_edge(8'h23, 8'h31, 1'b0, 8'd10,  1'b1, 1'b1); // R6 min kept 10
        send_edge(8'h24, 8'h35, 1'b0, 8'hFF,  1'b0, 1'b0); // R1 untouched label
        send_edge(8'h25, 8'h52, 1'b0, 8'hFF,  1'b0, 1'b1); // R7 offset 5 unchanged
        send_edge(8'h2F, 8'h53, 1'b1, 8'd3,   1'b1, 1'b0);
        edge_valid = 1'b0;
        edge_last  = 1'b0;
        chk("R10 scatter done", 32'(pass_done), 1);
        chk("R10 scatter count", 32'(pass_count), 4);
        chk("R5 one per clock count", 32'(pass_count), 4);
        @(negedge clk);
        chk("R2 drains", 32'(upd_out_valid), 0);
    endtask

    task automatic t_backpressure;
        pulse_start(1'b0);
        upd_out_ready = 1'b0;
        edge_valid = 1'b1; edge_src = 8'h23; edge_dst = 8'h70; edge_last = 1'b0;
        @(negedge clk);
        chk("R5 first taken", 32'(upd_out_dst), 32'h70);
        chk("R5 ready low on stall", 32'(edge_ready), 0);
        edge_src = 8'h24; edge_dst = 8'h71;
        @(negedge clk);
        chk("R5 held dst", 32'(upd_out_dst), 32'h70);
        chk("R5 held valid", 32'(upd_out_valid), 1);
        chk("R5 no accept", 32'(pass_count), 1);
        upd_out_ready = 1'b1;
        @(negedge clk);
        edge_valid = 1'b0;
        chk("R5 second dst", 32'(upd_out_dst), 32'h71);
        chk("R4 same bin", 32'(upd_out_bin_chg), 0);
        chk("R5 count two", 32'(pass_count), 2);
        @(negedge clk);
    endtask

    task automatic t_clear_active;
        pulse_start(1'b1);
        pulse_start(1'b0);
        send_edge(8'h23, 8'h10, 1'b0, 8'd10, 1'b0, 1'b1); // R9 flag cleared
        edge_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gather();
        t_scatter();
        t_backpressure();
        t_clear_active();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule